// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable model of a synchronous burst static RAM whose read path has no output register. Every control input, the address and the write data are captured on the rising clock edge. The word selected by that edge drives the read bus later in the same cycle. The array is 36 bits wide, built from four 9-bit lanes, and its depth is set by an address-width parameter.

There are two load strobes, one for a processor and one for a memory controller. A strobe loads a new address, but only while all three chip enables are in their selecting state. After a load, a two-bit burst counter forms the two low address bits and steps on cycles where no strobe is active. The counter steps in either interleaved or linear order. Writes are decoded from three levels of control: an all-lanes write input, a lane-write enable, and one write input per lane. The read bus driver is gated by the access type, an asynchronous output enable and a registered sleep input.

Top module: `ft_burst_sram`

## Requirements
- R1: A strobe (`cpu_ld_n` or `ctl_ld_n` low) loads `addr` only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A strobe seen while any one of these is in the other state deselects the part: from the next cycle `bus_drive`=0, and the array is not written.
- R2: With the part selected, `cpu_ld_n` low loads the address and starts a read whatever the write inputs are. The stored word appears on `rd_data` with `bus_drive`=1 in the cycle after that edge, with no added latency.
- R3: The lane write mask is derived as follows. If `wr_all_n`=0, all four lanes are written. If `wr_all_n`=1 and `lane_wr_en_n`=0, exactly the lanes whose `lane_wr_n[i]` is 0 are written, where lane i is data bits 9i+8 down to 9i. Any other setting is a read. A read also results when `lane_wr_en_n`=1, or when all four `lane_wr_n` bits are 1.
- R4: With the part selected, `ctl_ld_n` low loads the address and applies the decoded write mask, or reads if the mask is empty.
- R5: After a load, a cycle with both strobes high and `step_n`=0 changes only the two low address bits. When `order_sel`=0 they step linearly and wrap (s, s+1, s+2, s+3 mod 4). When `order_sel`=1 they follow s XOR 1, s XOR 2, s XOR 3 for the k-th step.
- R6: A cycle with both strobes high and `step_n`=1 holds the address. A write decoded in that cycle goes to the held address.
- R7: A write cycle sets `bus_drive` to 0. It stays 0 through later burst read cycles, until a strobe starts a new read.
- R8: `out_en_n`=1 forces `bus_drive`=0 at once, without waiting for a clock edge. Returning it to 0 restores the read data within the same cycle.
- R9: While the registered `sleep` is 1, `bus_drive`=0 and all strobes and writes are ignored. After `sleep` returns to 0, `bus_drive` stays 0 until a strobe starts a new read.
- R10: After reset, `bus_drive`=0 and no burst is active. Burst or write cycles without a prior load have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| cpu_ld_n | input | 1 | Processor load strobe, active low, always reads |
| ctl_ld_n | input | 1 | Controller load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| wr_all_n | input | 1 | All-lane write, active low |
| lane_wr_en_n | input | 1 | Enable for per-lane writes, active low |
| lane_wr_n | input | 4 | Per-lane write inputs, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, registered |
| addr | input | ADDR_W | Word address |
| wr_data | input | 36 | Write data |
| rd_data | output | 36 | Read data |
| bus_drive | output | 1 | Read bus driver enable |

## Verification
The bench targets burst wrap-around in both orders. A counter that carried into the upper address bits, or that added instead of XOR-ing, would return the wrong stored word. It checks that a burst read following a write stays undriven; a design that re-enabled the driver on any read would drive a stale word. The bench also checks that a processor strobe with active write inputs still reads, and that a single-lane write leaves the other lanes untouched. Finally, it confirms that strobes seen while deselected or asleep leave memory unchanged and the bus undriven, including the first idle cycle after sleep ends.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;

    localparam int BURST_W = 2;

    typedef logic [BURST_W-1:0] burst_t;

    // Next low address bits of a burst.
    function automatic burst_t burst_low(input logic interleave, input burst_t start,
                                         input burst_t cnt_nx, input burst_t cur);
        burst_t r;
        if (interleave) r = start ^ cnt_nx;
        else            r = cur + burst_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/ft_wr_decode.sv
module ft_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_mask
);
    // Priority: all-lane write, then per-lane writes, else read.
    always_comb begin
        if (!wr_all_n)          lane_mask = '1;
        else if (!lane_wr_en_n) lane_mask = ~lane_wr_n;
        else                    lane_mask = '0;
    end
endmodule

// File: rtl/ft_ctrl.sv
module ft_ctrl
    import ft_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              cpu_ld_n,
    input  logic              ctl_ld_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_mask,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              rd_act,
    output logic              slp_act,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        burst_t            start;
        burst_t            cnt;
        logic              active;
        logic              rd;
        logic              slp;
    } ctl_state_t;

    ctl_state_t st_q, st_d;
    logic       sel, strobe;
    burst_t     cnt_nx;

    assign sel    = !en_a_n && en_b && !en_c_n;
    assign strobe = !cpu_ld_n || !ctl_ld_n;
    assign cnt_nx = st_q.cnt + burst_t'(1);

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = st_q.addr;
        if (sleep) begin
            st_d.slp    = 1'b1;
            st_d.active = 1'b0;
            st_d.rd     = 1'b0;
        end else begin
            st_d.slp = 1'b0;
            if (strobe) begin
                if (sel) begin
                    st_d.addr   = addr;
                    st_d.start  = addr[BURST_W-1:0];
                    st_d.cnt    = '0;
                    st_d.active = 1'b1;
                    if (!cpu_ld_n || lane_mask == '0) begin
                        st_d.rd = 1'b1;
                    end else begin
                        st_d.rd = 1'b0;
                        wr_en   = 1'b1;
                        wr_addr = addr;
                    end
                end else begin
                    st_d.active = 1'b0;
                    st_d.rd     = 1'b0;
                end
            end else if (st_q.active) begin
                if (!step_n) begin
                    st_d.cnt = cnt_nx;
                    st_d.addr[BURST_W-1:0] = burst_low(order_sel, st_q.start, cnt_nx,
                                                       st_q.addr[BURST_W-1:0]);
                end
                if (lane_mask != '0) begin
                    wr_en   = 1'b1;
                    wr_addr = st_d.addr;
                    st_d.rd = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_addr = st_q.addr;
    assign rd_act   = st_q.rd;
    assign slp_act  = st_q.slp;

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel && !sleep) |=> !rd_act);                        // R1
    AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ld_n && sel && !sleep) |=> rd_act);                       // R2
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && cpu_ld_n && ctl_ld_n && step_n) |=> $stable(acc_addr)); // R6
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && cpu_ld_n && ctl_ld_n && !step_n && st_q.active && !order_sel)
        |=> acc_addr[BURST_W-1:0] == $past(acc_addr[BURST_W-1:0]) + burst_t'(1)); // R5
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_act);                                             // R7
endmodule

// File: rtl/ft_array.sv
module ft_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_mask[g])
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end
endmodule

// File: rtl/ft_burst_sram.sv
module ft_burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              cpu_ld_n,
    input  logic              ctl_ld_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic              wr_all_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              out_en_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_drive
);
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] acc_addr, wr_addr;
    logic              rd_act, slp_act, wr_en;

    ft_wr_decode #(.LANES(LANES)) u_dec (
        .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_wr_n(lane_wr_n), .lane_mask(lane_mask)
    );

    ft_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n), .step_n(step_n),
        .order_sel(order_sel), .sleep(sleep), .addr(addr), .lane_mask(lane_mask),
        .acc_addr(acc_addr), .rd_act(rd_act), .slp_act(slp_act),
        .wr_en(wr_en), .wr_addr(wr_addr)
    );

    ft_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .lane_mask(lane_mask),
        .wr_data(wr_data), .rd_addr(acc_addr), .rd_data(rd_data)
    );

    assign bus_drive = rd_act && !out_en_n && !slp_act;

    AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !bus_drive);                                          // R9
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !bus_drive);                                       // R8
endmodule

// File: tb/sim_ft_burst_sram.sv
module sim_ft_burst_sram;
    localparam logic [35:0] VA = 36'hA0A0A0A0A, VB = 36'hB1B1B1B1B, VC = 36'hC2C2C2C2C;
    localparam logic [35:0] VD = 36'hD3D3D3D3D, VE = 36'hE4E4E4E4E, VF = 36'hF5F5F5F5F;
    localparam logic [35:0] VG = 36'h969696969;
    localparam logic [35:0] LMASK = {9'h0, 9'h1FF, 9'h0, 9'h1FF};   // lanes 0 and 2
    localparam logic [35:0] VM = (VC & ~LMASK) | (VE & LMASK);

    typedef struct packed {
        logic        cpu_n, ctl_n, stp_n, all_n, len_n;
        logic [3:0]  lw_n;
        logic        mode;
        logic [5:0]  a;
        logic [35:0] din;
        logic        eoe;
        logic [35:0] edq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h10,VA,1'b0,36'h0,4'd4}, // R4 full write
        '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'h00,VB,1'b0,36'h0,4'd5}, // R5 burst write 0x11
        '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'h00,VC,1'b0,36'h0,4'd5}, // 0x12
        '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'h00,VD,1'b0,36'h0,4'd5}, // 0x13
        '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,36'h0,1'b0,36'h0,4'd7}, // R7 still undriven
        '{1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,6'h12,36'h0,1'b1,VC,4'd2}, // R2 forced read
        '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,36'h0,1'b1,VD,4'd5}, // R5 linear
        '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,36'h0,1'b1,VA,4'd5}, // R5 wrap
        '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h00,36'h0,1'b1,VA,4'd6}, // R6 hold
        '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,6'h11,36'h0,1'b1,VB,4'd2},
        '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'h00,36'h0,1'b1,VA,4'd5}, // R5 interleave
        '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'h00,36'h0,1'b1,VD,4'd5},
        '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'h00,36'h0,1'b1,VC,4'd5},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,4'b1010,1'b0,6'h12,VE,1'b0,36'h0,4'd3}, // R3 lanes 0,2
        '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h12,36'h0,1'b1,VM,4'd3},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,1'b0,6'h13,36'h0,1'b1,VD,4'd3}, // R3 no lanes
        '{1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,6'h13,36'h0,1'b1,VD,4'd3}, // R3 enable off
        '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h14,VF,1'b0,36'h0,4'd3},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h14,36'h0,1'b1,VF,4'd4},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,6'h00,VG,1'b0,36'h0,4'd6}, // R6 write on hold
        '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h14,36'h0,1'b1,VG,4'd6}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic cpu_ld_n = 1'b1, ctl_ld_n = 1'b1, step_n = 1'b1, order_sel = 1'b0;
    logic wr_all_n = 1'b1, lane_wr_en_n = 1'b1, out_en_n = 1'b0, sleep = 1'b0;
    logic [3:0]  lane_wr_n = 4'hF;
    logic [5:0]  addr = '0;
    logic [35:0] wr_data = '0, rd_data;
    logic        bus_drive;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    ft_burst_sram u0 (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n), .step_n(step_n), .order_sel(order_sel),
        .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .sleep(sleep), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .bus_drive(bus_drive)
    );

    task automatic chk(input string req, input logic eoe, input logic [35:0] edq);
        n_chk++;
        if (bus_drive !== eoe || (eoe && rd_data !== edq)) begin
            n_bad++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     req, bus_drive, rd_data, eoe, edq);
        end
    endtask

    task automatic drive(input logic c_n, input logic k_n, input logic s_n, input logic al_n,
                         input logic le_n, input logic [3:0] lw, input logic m,
                         input logic [5:0] a, input logic [35:0] d);
        cpu_ld_n = c_n; ctl_ld_n = k_n; step_n = s_n; wr_all_n = al_n;
        lane_wr_en_n = le_n; lane_wr_n = lw; order_sel = m; addr = a; wr_data = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h0, 36'h0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset", 1'b0, 36'h0);
        rst_n = 1'b1;
        // R10: burst step and write with no prior load do nothing
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 6'h0, VG);
        tick();
        chk("R10 no load", 1'b0, 36'h0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].cpu_n, TBL[i].ctl_n, TBL[i].stp_n, TBL[i].all_n, TBL[i].len_n,
                  TBL[i].lw_n, TBL[i].mode, TBL[i].a, TBL[i].din);
            tick();
            chk($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].eoe, TBL[i].edq);
        end

        // R1: strobes while deselected, one enable at a time
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h10, 36'h0);
        en_a_n = 1'b1; tick(); chk("R1 en_a", 1'b0, 36'h0);
        en_a_n = 1'b0; en_b = 1'b0; tick(); chk("R1 en_b", 1'b0, 36'h0);
        en_b = 1'b1; en_c_n = 1'b1; tick(); chk("R1 en_c", 1'b0, 36'h0);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 6'h10, VG);
        tick();
        en_c_n = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h10, 36'h0);
        tick();
        chk("R1 write ignored", 1'b1, VA);

        // R8: asynchronous output enable
        out_en_n = 1'b1;
        tick();
        chk("R8 forced off", 1'b0, 36'h0);
        idle();
        out_en_n = 1'b0;
        #1;
        chk("R8 restored", 1'b1, VA);

        // R9: sleep ignores a write and leaves the bus undriven on exit
        @(negedge clk);
        sleep = 1'b1;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 6'h10, VG);
        tick();
        chk("R9 asleep", 1'b0, 36'h0);
        sleep = 1'b0;
        idle();
        tick();
        chk("R9 wake undriven", 1'b0, 36'h0);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h10, 36'h0);
        tick();
        chk("R9 write ignored", 1'b1, VA);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule